// File: doc/BRIEF.md
# Link-Aware Transmit Frame Router

This block sits on the host-to-link transmit path. It accepts AXI-Stream frames coming out of the DMA side and hands each frame to one of several virtual-channel outputs. The destination field on the first beat of a frame picks the output. The chosen output then stays fixed until that frame's last beat, whatever the destination field shows on later beats.

When the outbound link is not ready, the router switches to a flush behaviour at the next frame boundary. It accepts every beat and throws it away, so the DMA source upstream never stalls on a dead link. A frame whose destination names no existing channel is also accepted and discarded.

Every forwarded frame has its first beat marked with a start-of-frame flag in bit 1 of the user sideband. The output side is one register stage: data, user and last are shared across the channels, and each channel has its own valid and ready.

Top module: `tx_frame_router`

## Requirements
- R1: While and after reset, with no input beat yet taken, every `m_tvalid` bit is 0 and `s_tready` is 1.
- R2: A frame whose first beat carries `s_tdest` in 0..N-1 while `link_up` is 1 appears on channel `s_tdest` only. Each accepted beat is presented with its data one cycle after the edge that took it, and at most one `m_tvalid` bit is high at any time.
- R3: Beats after the first beat of a frame go to the channel chosen at the first beat, whatever their own `s_tdest` holds.
- R4: A frame whose first beat arrives while `link_up` is 0 is dropped whole. None of its beats ever drives any `m_tvalid` bit.
- R5: While a frame is being dropped, `s_tready` is 1 whatever the state of `m_tready`.
- R6: Bit 1 of `m_tuser` is 1 on the first beat of each forwarded frame and 0 on every other forwarded beat. All other `m_tuser` bits equal `s_tuser`.
- R7: The forward/drop choice changes only at frame boundaries. A frame that started with the link up is forwarded to its end even if `link_up` falls. A frame that started with the link down is dropped to its end even if `link_up` rises. The frame after either one follows the link state at its own first beat.
- R8: A frame whose first beat has `s_tdest` of N or above is accepted with `s_tready` 1 and dropped whole.
- R9: When the output register holds a beat whose channel has `m_tready` 0, `s_tready` is 0 for a beat that would be forwarded. The held beat's valid, data and last stay unchanged until that channel takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Outbound link ready; low selects flush at the next frame start |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | DATA_W | Input beat data |
| s_tuser | input | USER_W | Input sideband; bit 1 is overwritten with the start-of-frame flag |
| s_tdest | input | DEST_W | Destination channel, sampled on the first beat of a frame |
| s_tlast | input | 1 | Last beat of frame |
| m_tvalid | output | N | Per-channel output valid, at most one bit set |
| m_tready | input | N | Per-channel output ready |
| m_tdata | output | DATA_W | Output data, shared by all channels |
| m_tuser | output | USER_W | Output sideband with start-of-frame flag in bit 1 |
| m_tlast | output | 1 | Output last beat of frame |

## Verification
The bench aims at link transitions in the middle of a frame. A router that re-read the link state on every beat would truncate a forwarded frame, or leak the tail of a dropped frame, and both show up as wrong `m_tvalid` patterns. It also changes `s_tdest` inside a frame: a router that did not lock the channel would split that frame across two outputs. Stalled channels are combined with a flush and with an out-of-range destination. Checked there: a dropping router still raises `s_tready`, and it does not overwrite the beat held for the stalled channel. Beats that arrive while the held channel is stalled are also checked, since a router that ignored the stall would clobber the held beat or accept a beat it cannot store.

// File: rtl/tx_router_pkg.sv
package tx_router_pkg;
  // Bit of the user sideband that carries the start-of-frame flag.
  localparam int SOF_BIT = 1;
endpackage

// File: rtl/txr_frame_track.sv
module txr_frame_track #(
  parameter int N      = 4,
  parameter int DEST_W = 3,
  localparam int CH_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up,
  input  logic              take,
  input  logic              s_tlast,
  input  logic [DEST_W-1:0] s_tdest,
  output logic              first,
  output logic              drop_now,
  output logic [CH_W-1:0]   ch_now
);
  logic            first_q;
  logic            drop_q;
  logic [CH_W-1:0] ch_q;
  logic            dest_bad;

  assign dest_bad = s_tdest > DEST_W'(N - 1);
  assign first    = first_q;
  assign drop_now = first_q ? (!link_up || dest_bad) : drop_q;
  assign ch_now   = first_q ? s_tdest[CH_W-1:0] : ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      drop_q  <= 1'b0;
      ch_q    <= '0;
    end else if (take) begin
      first_q <= s_tlast;
      if (first_q) begin
        drop_q <= drop_now;
        ch_q   <= ch_now;
      end
    end
  end
endmodule

// File: rtl/txr_out_stage.sv
module txr_out_stage #(
  parameter int N      = 4,
  parameter int DATA_W = 64,
  parameter int USER_W = 2,
  localparam int CH_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CH_W-1:0]   ld_ch,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [USER_W-1:0] ld_user,
  input  logic              ld_last,
  input  logic [N-1:0]      m_tready,
  output logic [N-1:0]      m_tvalid,
  output logic [DATA_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast,
  output logic              slot_free
);
  logic            vld_q;
  logic [CH_W-1:0] ch_q;

  assign slot_free = !vld_q || m_tready[ch_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ch_q  <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      ch_q  <= ld_ch;
    end else if (slot_free) begin
      vld_q <= 1'b0;
    end
  end

  // Payload registers carry no reset: only valid qualifies them.
  always_ff @(posedge clk) begin
    if (load) begin
      m_tdata <= ld_data;
      m_tuser <= ld_user;
      m_tlast <= ld_last;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_vld
    assign m_tvalid[i] = vld_q && (ch_q == CH_W'(i));
  end
endmodule

// File: rtl/tx_frame_router.sv
module tx_frame_router #(
  parameter int N      = 4,
  parameter int DATA_W = 64,
  parameter int USER_W = 2,
  parameter int DEST_W = 3,
  localparam int CH_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [USER_W-1:0] s_tuser,
  input  logic [DEST_W-1:0] s_tdest,
  input  logic              s_tlast,
  output logic [N-1:0]      m_tvalid,
  input  logic [N-1:0]      m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast
);
  import tx_router_pkg::*;

  logic            take;
  logic            first;
  logic            drop_now;
  logic [CH_W-1:0] ch_now;
  logic            slot_free;
  logic [USER_W-1:0] user_marked;

  assign s_tready = drop_now || slot_free;
  assign take     = s_tvalid && s_tready;

  always_comb begin
    user_marked          = s_tuser;
    user_marked[SOF_BIT] = first;
  end

  txr_frame_track #(.N(N), .DEST_W(DEST_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .link_up  (link_up),
    .take     (take),
    .s_tlast  (s_tlast),
    .s_tdest  (s_tdest),
    .first    (first),
    .drop_now (drop_now),
    .ch_now   (ch_now)
  );

  txr_out_stage #(.N(N), .DATA_W(DATA_W), .USER_W(USER_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (take && !drop_now),
    .ld_ch     (ch_now),
    .ld_data   (s_tdata),
    .ld_user   (user_marked),
    .ld_last   (s_tlast),
    .m_tready  (m_tready),
    .m_tvalid  (m_tvalid),
    .m_tdata   (m_tdata),
    .m_tuser   (m_tuser),
    .m_tlast   (m_tlast),
    .slot_free (slot_free)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int N      = 4,
  parameter int DATA_W = 64,
  parameter int USER_W = 2,
  parameter int DEST_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              link_up,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic [DEST_W-1:0] s_tdest,
  input logic              first,
  input logic              drop_now,
  input logic [N-1:0]      m_tvalid,
  input logic [N-1:0]      m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic [USER_W-1:0] m_tuser,
  input logic              m_tlast
);
  // Output-side frame tracking, independent of the input-side tracker.
  logic exp_first;
  always_ff @(posedge clk) begin
    if (rst) exp_first <= 1'b1;
    else if (|(m_tvalid & m_tready)) exp_first <= m_tlast;
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_tvalid));

  a_r5_flush_no_stall: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && first && !link_up) |-> s_tready);

  a_r8_bad_dest_ready: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && first && (s_tdest > DEST_W'(N - 1))) |-> s_tready);

  a_r4_drop_no_load: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready && drop_now) |=>
      (m_tvalid == ($past(m_tvalid) & ~$past(m_tready))));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (|(m_tvalid & ~m_tready)) |=>
      ($stable(m_tvalid) && $stable(m_tdata) && $stable(m_tlast)));

  a_r6_sof_flag: assert property (@(posedge clk) disable iff (rst)
    (|m_tvalid) |-> (m_tuser[1] == exp_first));
endmodule

bind tx_frame_router txr_checker #(
  .N(N), .DATA_W(DATA_W), .USER_W(USER_W), .DEST_W(DEST_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .link_up  (link_up),
  .s_tvalid (s_tvalid),
  .s_tready (s_tready),
  .s_tdest  (s_tdest),
  .first    (first),
  .drop_now (drop_now),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tdata  (m_tdata),
  .m_tuser  (m_tuser),
  .m_tlast  (m_tlast)
);

// File: tb/tx_frame_router_bench.sv
module tx_frame_router_bench;
  localparam int N = 4, DATA_W = 16, USER_W = 2, DEST_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b0;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [DATA_W-1:0] s_tdata = '0;
  logic [USER_W-1:0] s_tuser = 2'b11;
  logic [DEST_W-1:0] s_tdest = '0;
  logic s_tlast = 1'b0;
  logic [N-1:0] m_tvalid;
  logic [N-1:0] m_tready = '1;
  logic [DATA_W-1:0] m_tdata;
  logic [USER_W-1:0] m_tuser;
  logic m_tlast;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  tx_frame_router #(.N(N), .DATA_W(DATA_W), .USER_W(USER_W), .DEST_W(DEST_W))
  u_tx_frame_router (
    .clk(clk), .rst(rst), .link_up(link_up),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tuser(s_tuser), .s_tdest(s_tdest), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tuser(m_tuser), .m_tlast(m_tlast)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Packed entry: {link[17], dest[16:14], last[13], data[12:5], exp_vld[4:1], exp_sof[0]}
  localparam logic [17:0] TBL [11] = '{
    {1'b1, 3'd2, 1'b0, 8'hA0, 4'b0100, 1'b1},  // R2 frame to ch2, first beat
    {1'b1, 3'd0, 1'b1, 8'hA1, 4'b0100, 1'b0},  // R3 dest changes, stays on ch2
    {1'b0, 3'd1, 1'b0, 8'hB0, 4'b0000, 1'b0},  // R4 link down at frame start
    {1'b1, 3'd1, 1'b1, 8'hB1, 4'b0000, 1'b0},  // R7 link back mid-drop, still dropped
    {1'b1, 3'd5, 1'b1, 8'hC0, 4'b0000, 1'b0},  // R8 out-of-range dest
    {1'b1, 3'd3, 1'b1, 8'hD0, 4'b1000, 1'b1},  // R2 single-beat frame to ch3
    {1'b1, 3'd1, 1'b0, 8'hE0, 4'b0010, 1'b1},  // R2 frame to ch1
    {1'b0, 3'd0, 1'b0, 8'hE1, 4'b0010, 1'b0},  // R7 link falls mid-frame, forwarded
    {1'b0, 3'd0, 1'b1, 8'hE2, 4'b0010, 1'b0},  // R7 tail still forwarded
    {1'b0, 3'd0, 1'b1, 8'hF0, 4'b0000, 1'b0},  // R4 next frame dropped
    {1'b1, 3'd0, 1'b1, 8'h70, 4'b0001, 1'b1}   // R7 link up again, forwarded
  };
  localparam int TAG [11] = '{2, 3, 4, 7, 8, 2, 2, 7, 7, 4, 7};

  task automatic drive(input logic lk, input logic [DEST_W-1:0] d, input logic l,
                       input logic [DATA_W-1:0] dat);
    link_up = lk; s_tvalid = 1'b1; s_tdest = d; s_tlast = l; s_tdata = dat;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", 32'(m_tvalid), 0);
    rst = 1'b0;
    #1;
    check("R1 ready after reset", 32'(s_tready), 1);
    check("R1 valid after reset", 32'(m_tvalid), 0);

    for (int i = 0; i < 11; i++) begin
      string tg;
      tg = $sformatf("R%0d entry %0d", TAG[i], i);
      drive(TBL[i][17], TBL[i][16:14], TBL[i][13], DATA_W'(TBL[i][12:5]));
      #1;
      check({tg, " ready"}, 32'(s_tready), 1);
      @(posedge clk);
      @(negedge clk);
      check({tg, " valid"}, 32'(m_tvalid), 32'(TBL[i][4:1]));
      if (TBL[i][4:1] != 0) begin
        check({tg, " data"}, 32'(m_tdata), 32'(TBL[i][12:5]));
        check({tg, " R6 user"}, 32'(m_tuser), 32'({TBL[i][0], 1'b1}));
        check({tg, " last"}, 32'(m_tlast), 32'(TBL[i][13]));
      end
    end

    // R9: ch2 stalled, second beat must wait and held beat must not change
    m_tready = 4'b1011;
    drive(1'b1, 3'd2, 1'b0, 16'h0055);
    #1;
    check("R9 first beat ready", 32'(s_tready), 1);
    @(posedge clk); @(negedge clk);
    check("R9 held valid", 32'(m_tvalid), 32'(4'b0100));
    drive(1'b1, 3'd0, 1'b1, 16'h0056);
    #1;
    check("R9 ready low on stall", 32'(s_tready), 0);
    @(posedge clk); @(negedge clk);
    check("R9 data held", 32'(m_tdata), 32'h55);
    check("R9 valid held", 32'(m_tvalid), 32'(4'b0100));
    m_tready = 4'b1111;
    #1;
    check("R9 ready on release", 32'(s_tready), 1);
    @(posedge clk); @(negedge clk);
    check("R3 second beat data", 32'(m_tdata), 32'h56);
    check("R3 second beat channel", 32'(m_tvalid), 32'(4'b0100));
    check("R6 second beat flag", 32'(m_tuser), 32'(2'b01));

    // R5/R4: flush while the held beat's channel is stalled
    m_tready = 4'b0000;
    drive(1'b0, 3'd1, 1'b1, 16'h0077);
    #1;
    check("R5 flush ready under stall", 32'(s_tready), 1);
    @(posedge clk); @(negedge clk);
    check("R4 dropped beat not loaded", 32'(m_tdata), 32'h56);
    check("R4 valid unchanged", 32'(m_tvalid), 32'(4'b0100));
    // R8 bad destination while link up and stalled
    drive(1'b1, 3'd6, 1'b1, 16'h0088);
    #1;
    check("R8 bad dest ready under stall", 32'(s_tready), 1);
    @(posedge clk); @(negedge clk);
    check("R8 bad dest not loaded", 32'(m_tdata), 32'h56);
    s_tvalid = 1'b0;
    m_tready = 4'b1111;
    @(posedge clk); @(negedge clk);
    check("R2 drained", 32'(m_tvalid), 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule